// File: doc/BRIEF.md
# Instruction Stream Cache Compressor

This block watches the flow of committed program-counter values and cuts it into instruction streams. A stream is a run of instructions whose addresses rise by 4. Each stream is described by its first address and its instruction count. Finished descriptors wait in a small FIFO. A lookup engine then checks each one against a set-associative stream cache. When the descriptor is already cached, the block replaces the whole stream with a short index. When it is not, the block sends a reserved code plus the full descriptor, and then installs the descriptor in the cache.

The index channel carries one entry for every stream. The miss channel carries the descriptors the cache did not hold. A downstream decoder with an identical cache can rebuild the address trace from these two channels. Both outputs use valid/ready handshakes, so the consumer can apply back-pressure. The program-counter side is never stalled. The FIFO absorbs the short burst that a run of very short streams can produce.

Top module: `isc_compressor`

## Requirements
- R1: A stream ends when a valid PC is not equal to the previous valid PC plus 4. That PC then becomes the start address of the next stream. Cycles without a valid PC do not break a stream.
- R2: A descriptor is a 32-bit start address and an 8-bit length. The length is the number of instructions in the stream, from 1 to 255.
- R3: Closed descriptors enter a FIFO of FIFO_DEPTH entries (at least 2) and are looked up in arrival order. None is lost or reordered while the FIFO does not overflow.
- R4: The set is start[6+n-1:6] XOR length[n-1:0], with n = log2(NSETS). On a hit, idx_data is {set, way}, with the set in the upper bits.
- R5: On a miss, idx_data is 0 and the same descriptor appears on the miss channel, in order.
- R6: On a miss, the victim is the lowest-numbered invalid way of the set. When every way is valid, a tree pseudo-LRU picks the victim. Both hits and fills update that tree.
- R7: A stream is closed once it holds 255 instructions. The next PC starts a new stream even when it is sequential.
- R8: A pulse on task_switch closes any open stream. The next valid PC always starts a new stream.
- R9: Way 0 of set 0 is never allocated, so a hit index is never 0.
- R10: Reset clears every valid bit and both output valids. The first PC after reset opens a stream.
- R11: A lookup that hits takes one engine cycle. A miss takes two: one to emit and one to fill the cache.
- R12: An output whose valid is high while its ready is low keeps its valid and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 1 | A committed PC is presented |
| pc | input | 32 | Committed program-counter value |
| task_switch | input | 1 | Closes the open stream |
| idx_valid | output | 1 | Index channel valid |
| idx_ready | input | 1 | Index channel ready |
| idx_data | output | log2(NSETS)+log2(NWAYS) | {set, way} on a hit, 0 on a miss |
| miss_valid | output | 1 | Miss channel valid |
| miss_ready | input | 1 | Miss channel ready |
| miss_start | output | 32 | Start address of the missed stream |
| miss_len | output | 8 | Length of the missed stream |

## Verification
The bench builds the block with NSETS=4, NWAYS=4 and FIFO_DEPTH=4. With only four sets, a pool of ten recurring streams keeps colliding in the same sets. This quickly fills sets, so pseudo-LRU evictions and the set-0 way-0 exclusion occur many times in one run. The small FIFO depth lets a burst of single-instruction streams come close to the FIFO limit. A 300-instruction straight run reaches the 255 length cap.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int unsigned SA_W   = 32;
   localparam int unsigned SL_W   = 8;
   localparam int unsigned SL_MAX = 255;
   localparam int unsigned STEP   = 4;

   typedef struct packed {
      logic [SA_W-1:0] sa;
      logic [SL_W-1:0] sl;
   } stream_t;
endpackage

// File: rtl/isc_stream_detect.sv
module isc_stream_detect
   import isc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pc_valid,
   input  logic [SA_W-1:0] pc,
   input  logic            task_switch,
   output logic            push,
   output stream_t         desc
);
   logic            open_q;
   logic [SA_W-1:0] prev_q;
   stream_t         cur_q;
   logic            seq;

   // continue the open stream only on a +4 step below the length cap
   assign seq  = open_q && !task_switch && (pc == prev_q + SA_W'(STEP))
               && (cur_q.sl != SL_W'(SL_MAX));
   assign push = open_q && (task_switch || (pc_valid && !seq));
   assign desc = cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         prev_q <= '0;
         cur_q  <= '0;
      end else if (pc_valid) begin
         prev_q <= pc;
         open_q <= 1'b1;
         if (seq) cur_q.sl <= cur_q.sl + SL_W'(1);
         else     cur_q    <= '{sa: pc, sl: SL_W'(1)};
      end else if (task_switch) begin
         open_q <= 1'b0;
      end
   end

   // R2
   len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> desc.sl != '0);
   // R1
   new_stream_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(push) && $past(pc_valid) |-> cur_q.sl == SL_W'(1));
endmodule

// File: rtl/isc_fifo.sv
module isc_fifo
   import isc_pkg::*;
#(
   parameter  int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
)(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    push,
   input  stream_t wdata,
   input  logic    pop,
   output logic    empty,
   output logic    full,
   output stream_t rdata
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("isc_fifo: DEPTH must be at least 2");
      end
   endgenerate

   stream_t          mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wr, rd;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);
   assign wr    = push && !full;
   assign rd    = pop && !empty;
   assign rdata = mem[rp_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr) wp_q <= bump(wp_q);
         if (rd) rp_q <= bump(rp_q);
         cnt_q <= cnt_q + CNT_W'(wr) - CNT_W'(rd);
      end
   end

   always_ff @(posedge clk) begin
      if (wr) mem[wp_q] <= wdata;
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R3
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/isc_cache.sv
module isc_cache
   import isc_pkg::*;
#(
   parameter  int unsigned NSETS = 16,
   parameter  int unsigned NWAYS = 4,
   localparam int unsigned SET_W = $clog2(NSETS),
   localparam int unsigned WAY_W = $clog2(NWAYS),
   localparam int unsigned IDX_W = SET_W + WAY_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  stream_t          req,
   output logic             req_pop,
   output logic             idx_valid,
   input  logic             idx_ready,
   output logic [IDX_W-1:0] idx_data,
   output logic             miss_valid,
   input  logic             miss_ready,
   output stream_t          miss_desc
);
   generate
      if (NWAYS < 2 || (1 << WAY_W) != NWAYS) begin : g_bad_ways
         $error("isc_cache: NWAYS must be a power of two, at least 2");
      end
      if (SET_W < 1 || SET_W > SL_W || (1 << SET_W) != NSETS) begin : g_bad_sets
         $error("isc_cache: NSETS must be a power of two from 2 to 256");
      end
   endgenerate

   // heap-ordered tree: node 1 is the root, bit 0 unused
   logic              vld_q  [NSETS][NWAYS];
   logic [SA_W-1:0]   sa_q   [NSETS][NWAYS];
   logic [SL_W-1:0]   sl_q   [NSETS][NWAYS];
   logic [NWAYS-1:0]  plru_q [NSETS];

   logic [SET_W-1:0]  set_i;
   logic [NWAYS-1:0]  hit_vec;
   logic [WAY_W-1:0]  hit_way, victim;
   logic              hit, fill_q, out_free, issue;

   function automatic logic [WAY_W-1:0] plru_pick(input logic [NWAYS-1:0] t);
      logic [WAY_W-1:0] node, v;
      node = WAY_W'(1);
      v    = '0;
      for (int l = 0; l < WAY_W; l++) begin
         v    = WAY_W'({v, t[node]});
         node = WAY_W'({node, t[node]});
      end
      return v;
   endfunction

   function automatic logic [NWAYS-1:0] plru_touch(input logic [NWAYS-1:0] t,
                                                   input logic [WAY_W-1:0] w);
      logic [WAY_W-1:0] node, rest;
      logic             d;
      node = WAY_W'(1);
      rest = w;
      for (int l = 0; l < WAY_W; l++) begin
         d       = rest[WAY_W-1];
         t[node] = ~d;
         node    = WAY_W'({node, d});
         rest    = rest << 1;
      end
      return t;
   endfunction

   assign set_i = req.sa[6 +: SET_W] ^ req.sl[SET_W-1:0];

   generate
      for (genvar w = 0; w < NWAYS; w++) begin : g_way
         assign hit_vec[w] = vld_q[set_i][w] && (sa_q[set_i][w] == req.sa)
                          && (sl_q[set_i][w] == req.sl);
      end
   endgenerate

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < NWAYS; w++)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end

   always_comb begin
      victim = plru_pick(plru_q[set_i]);
      if (set_i == '0 && victim == '0) victim = WAY_W'(1);
      for (int w = NWAYS - 1; w >= 0; w--)
         if (!vld_q[set_i][w] && !(set_i == '0 && w == 0)) victim = WAY_W'(w);
   end

   assign out_free = (!idx_valid || idx_ready) && (!miss_valid || miss_ready);
   assign issue    = req_valid && !fill_q && out_free;
   assign req_pop  = (issue && hit) || fill_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_valid  <= 1'b0;
         idx_data   <= '0;
         miss_valid <= 1'b0;
         miss_desc  <= '0;
         fill_q     <= 1'b0;
      end else begin
         fill_q <= issue && !hit;
         if (issue) begin
            idx_valid <= 1'b1;
            idx_data  <= hit ? {set_i, hit_way} : '0;
         end else if (idx_ready) begin
            idx_valid <= 1'b0;
         end
         if (issue && !hit) begin
            miss_valid <= 1'b1;
            miss_desc  <= req;
         end else if (miss_ready) begin
            miss_valid <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NSETS; s++) begin
            plru_q[s] <= '0;
            for (int w = 0; w < NWAYS; w++) vld_q[s][w] <= 1'b0;
         end
      end else begin
         if (issue && hit) plru_q[set_i] <= plru_touch(plru_q[set_i], hit_way);
         if (fill_q) begin
            vld_q[set_i][victim] <= 1'b1;
            plru_q[set_i]        <= plru_touch(plru_q[set_i], victim);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_q) begin
         sa_q[set_i][victim] <= req.sa;
         sl_q[set_i][victim] <= req.sl;
      end
   end

   // R6
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot0(hit_vec));
   // R9
   no_home_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q[0][0]);
   // R5
   zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idx_valid) && idx_data == '0 |-> miss_valid);
   // R11
   fill_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q |-> req_valid && req_pop);
   // R11
   fill_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q |=> !fill_q);
   // R12
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid && !idx_ready |=> idx_valid && $stable(idx_data));
   // R12
   miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid && !miss_ready |=> miss_valid && $stable(miss_desc));
endmodule

// File: rtl/isc_compressor.sv
module isc_compressor
   import isc_pkg::*;
#(
   parameter int unsigned NSETS      = 16,
   parameter int unsigned NWAYS      = 4,
   parameter int unsigned FIFO_DEPTH = 4
)(
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   pc_valid,
   input  logic [31:0]                            pc,
   input  logic                                   task_switch,
   output logic                                   idx_valid,
   input  logic                                   idx_ready,
   output logic [$clog2(NSETS)+$clog2(NWAYS)-1:0] idx_data,
   output logic                                   miss_valid,
   input  logic                                   miss_ready,
   output logic [31:0]                            miss_start,
   output logic [7:0]                             miss_len
);
   generate
      if (FIFO_DEPTH < 2) begin : g_bad_fifo
         $error("isc_compressor: FIFO_DEPTH must be at least 2");
      end
   endgenerate

   logic    det_push, fifo_empty, fifo_full, head_pop;
   stream_t det_desc, head, miss_d;

   isc_stream_detect u_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .pc_valid    (pc_valid),
      .pc          (pc),
      .task_switch (task_switch),
      .push        (det_push),
      .desc        (det_desc)
   );

   isc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (det_push),
      .wdata (det_desc),
      .pop   (head_pop),
      .empty (fifo_empty),
      .full  (fifo_full),
      .rdata (head)
   );

   isc_cache #(.NSETS(NSETS), .NWAYS(NWAYS)) u_cache (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (!fifo_empty),
      .req        (head),
      .req_pop    (head_pop),
      .idx_valid  (idx_valid),
      .idx_ready  (idx_ready),
      .idx_data   (idx_data),
      .miss_valid (miss_valid),
      .miss_ready (miss_ready),
      .miss_desc  (miss_d)
   );

   assign miss_start = miss_d.sa;
   assign miss_len   = miss_d.sl;

   // R3
   fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !det_push || head_pop);
endmodule

// File: tb/isc_compressor_test.sv
module isc_compressor_test;
   localparam int NS = 4;
   localparam int NW = 4;
   localparam int FD = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pc_valid = 1'b0;
   logic [31:0] pc = '0;
   logic        task_switch = 1'b0;
   logic        idx_ready = 1'b1;
   logic        miss_ready = 1'b1;
   logic        idx_valid, miss_valid;
   logic [3:0]  idx_data;
   logic [31:0] miss_start;
   logic [7:0]  miss_len;

   always #2 clk = ~clk;

   isc_compressor #(.NSETS(NS), .NWAYS(NW), .FIFO_DEPTH(FD)) uut (
      .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc),
      .task_switch(task_switch), .idx_valid(idx_valid), .idx_ready(idx_ready),
      .idx_data(idx_data), .miss_valid(miss_valid), .miss_ready(miss_ready),
      .miss_start(miss_start), .miss_len(miss_len)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference cache
   bit          mv  [NS][NW];
   logic [31:0] msa [NS][NW];
   logic [7:0]  msl [NS][NW];
   bit [3:0]    mt  [NS];
   int          exp_idx[$];
   string       exp_itag[$];
   logic [39:0] exp_miss[$];
   string       exp_mtag[$];

   function automatic int pick(input bit [3:0] t);
      if (t[1]) return t[3] ? 3 : 2;
      return t[2] ? 1 : 0;
   endfunction

   function automatic bit [3:0] touch(input bit [3:0] t, input int w);
      t[1] = (w < 2);
      if (w >= 2) t[3] = ((w & 1) == 0);
      else        t[2] = ((w & 1) == 0);
      return t;
   endfunction

   function automatic void ref_lookup(input logic [31:0] sa, input logic [7:0] sl, input string why);
      int s, hw, v;
      s  = int'(sa[7:6] ^ sl[1:0]);
      hw = -1;
      for (int w = 0; w < NW; w++)
         if (mv[s][w] && msa[s][w] == sa && msl[s][w] == sl) hw = w;
      if (hw >= 0) begin
         exp_idx.push_back(s * NW + hw);
         exp_itag.push_back(s == 0 ? "R9 R4" : "R4 R6");
         mt[s] = touch(mt[s], hw);
      end else begin
         exp_idx.push_back(0);
         exp_itag.push_back("R5");
         exp_miss.push_back({sa, sl});
         exp_mtag.push_back(why);
         v = -1;
         for (int w = 0; w < NW; w++)
            if (v < 0 && !mv[s][w] && !(s == 0 && w == 0)) v = w;
         if (v < 0) begin
            v = pick(mt[s]);
            if (s == 0 && v == 0) v = 1;
         end
         mv[s][v] = 1; msa[s][v] = sa; msl[s][v] = sl;
         mt[s] = touch(mt[s], v);
      end
   endfunction

   // reference stream splitter
   bit          m_open = 0;
   logic [31:0] m_prev, m_sa;
   logic [7:0]  m_sl;

   task automatic drive(input logic [31:0] p);
      bit seq;
      @(posedge clk); #1;
      pc_valid = 1; pc = p; task_switch = 0;
      seq = m_open && (p == m_prev + 32'd4) && (m_sl != 8'd255);
      if (m_open && !seq)
         ref_lookup(m_sa, m_sl, (p == m_prev + 32'd4) ? "R7" : "R1 R2");
      if (seq) m_sl = m_sl + 8'd1;
      else begin m_sa = p; m_sl = 8'd1; end
      m_prev = p; m_open = 1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         pc_valid = 0; task_switch = 0;
      end
   endtask

   task automatic flush();
      @(posedge clk); #1;
      pc_valid = 0; task_switch = 1;
      if (m_open) ref_lookup(m_sa, m_sl, "R8");
      m_open = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (idx_valid && idx_ready) begin
            if (exp_idx.size() == 0) chk(0, "R3 unexpected index", idx_data, 0);
            else begin
               int e; string t;
               e = exp_idx.pop_front(); t = exp_itag.pop_front();
               chk(idx_data == 4'(e), t, idx_data, e);
            end
         end
         if (miss_valid && miss_ready) begin
            if (exp_miss.size() == 0) chk(0, "R5 unexpected miss", miss_start, 0);
            else begin
               logic [39:0] e; string t;
               e = exp_miss.pop_front(); t = exp_mtag.pop_front();
               chk({miss_start, miss_len} == e, t, {miss_start, miss_len}, e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   logic [31:0] pool_sa[10];
   logic [7:0]  pool_sl[10];

   initial begin
      logic [3:0] held;
      void'($urandom(32'd24680));
      for (int s = 0; s < NS; s++) begin
         mt[s] = '0;
         for (int w = 0; w < NW; w++) mv[s][w] = 0;
      end
      repeat (4) @(negedge clk);
      chk(!idx_valid && !miss_valid, "R10 outputs idle in reset", {idx_valid, miss_valid}, 0);
      @(posedge clk); #1; rst_n = 1;
      idle(2);
      chk(!idx_valid && !miss_valid, "R10 outputs idle after reset", {idx_valid, miss_valid}, 0);

      // first streams after reset, then repeated for hits
      drive(32'h100); drive(32'h104); drive(32'h108);
      drive(32'h200); drive(32'h204);
      drive(32'h100); drive(32'h104); drive(32'h108);
      drive(32'h200); drive(32'h204);
      drive(32'h300);
      idle(2);
      drive(32'h304);              // gap does not break a stream (R1)
      drive(32'h100);
      idle(6);

      // length cap
      for (int i = 0; i < 300; i++) drive(32'h8000 + 32'(i) * 4);
      drive(32'h8800);
      idle(6);

      // task switch: sequential PC after the flush starts a new stream
      drive(32'h9000); drive(32'h9004);
      flush();
      drive(32'h9008);
      drive(32'h9100);
      idle(6);

      // burst of single-instruction streams
      drive(32'hA000); drive(32'hB000); drive(32'hC000); drive(32'hD000);
      idle(12);

      // back-pressure on both channels
      @(posedge clk); #1; idx_ready = 0; miss_ready = 0;
      drive(32'hE000); drive(32'hE004); drive(32'hF000);
      idle(6);
      @(negedge clk);
      chk(idx_valid == 1, "R12 index held under stall", idx_valid, 1);
      chk(miss_valid == 1, "R12 miss held under stall", miss_valid, 1);
      held = idx_data;
      idle(4);
      @(negedge clk);
      chk(idx_valid == 1 && idx_data == held, "R12 index stable", idx_data, held);
      @(posedge clk); #1; idx_ready = 1; miss_ready = 1;
      idle(8);

      // constrained random traffic over a recurring stream pool
      for (int k = 0; k < 10; k++) begin
         pool_sa[k] = 32'h0010_0000 + 32'(k) * 32'h1000 + (32'($urandom % 4) << 6);
         pool_sl[k] = 8'(2 + $urandom % 14);
      end
      for (int n = 0; n < 200; n++) begin
         int k;
         k = int'($urandom % 10);
         for (int i = 0; i < int'(pool_sl[k]); i++) begin
            drive(pool_sa[k] + 32'(i) * 4);
            if ($urandom % 5 == 0) idle(1);
         end
      end
      flush();
      idle(40);

      chk(exp_idx.size() == 0, "R3 every index delivered", exp_idx.size(), 0);
      chk(exp_miss.size() == 0, "R3 every miss delivered", exp_miss.size(), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule